// File: doc/BRIEF.md
# Triggered Timer with Interrupt Postscaler

This block is a 16-bit time base with an interrupt postscaler and a synchronization output. The counter runs from zero up to a programmed period value and wraps. It either free-runs or waits for a rising edge on an external trigger. A run that is started by a trigger can be restarted by a later trigger, and it can be limited to a programmed number of periods (one-shot).

The postscaler divides one kind of event and then raises a one-cycle interrupt. The event is either a period match or an accepted trigger. In capture mode it is a capture strobe instead. Capture mode only allows ratios up to 1:4, and an error flag reports any larger setting. The sync output carries either the time base restart/rollover event or an alternate input.

All configuration arrives on one 11-bit control word. When every bit is zero the module is off. Setting only the module-on bit gives a free-running timer with a 1:1 postscale of period matches and rollover-driven sync.

Top module: `trig_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, `irq`, `sync_out` and `cfg_err` are 0, `tmr_count` is 0 and `tmr_running` is 0 when the control word is all zero.
- R2: With module-on (control bit 0) set and trigger-enable (bit 1) clear, the counter advances once per clock from 0 to `period`, then returns to 0, so the period is `period`+1 cycles. A period match is the cycle in which the count equals `period`.
- R3: With ratio field N (control bits 10:7), `irq` rises for exactly one cycle on every (N+1)th counted event, one clock after that event.
- R4: With bit 4 set (and bit 5 clear), the postscaler counts accepted triggers instead of period matches.
- R5: With capture mode (bit 5) set, the postscaler counts cycles in which `cap_strobe` is high.
- R6: `cfg_err` is 1 exactly when module-on, capture mode and N greater than 3 all hold.
- R7: With bit 1 set, the time base stays idle at count 0 until a rising edge of `trig_in`, which passes through two synchronizing flip-flops and an edge detector. Each edge counts once.
- R8: While a triggered run is in progress, a new trigger edge restarts the count at 0 only when retrigger (bit 2) is set. Otherwise the count continues.
- R9: With one-shot (bit 3) and bit 1 set, a trigger starts a run of `shot_len`+1 periods, after which the time base returns to idle at count 0.
- R10: With bit 6 clear, `sync_out` pulses on every period match and every accepted trigger. With bit 6 set, it equals `alt_sync_in`.
- R11: The postscaler's event count returns to zero while module-on is clear and in any cycle in which the ratio field differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 11 | Control word: [0] on, [1] trigger enable, [2] retrigger, [3] one-shot, [4] postscale source, [5] capture mode, [6] alternate sync, [10:7] ratio |
| period | input | 16 | Terminal count of the time base |
| shot_len | input | 3 | One-shot length minus one, in periods |
| trig_in | input | 1 | Asynchronous trigger input |
| cap_strobe | input | 1 | One-cycle capture event |
| alt_sync_in | input | 1 | Alternate sync source |
| irq | output | 1 | One-cycle interrupt pulse |
| sync_out | output | 1 | Synchronization output |
| cfg_err | output | 1 | Illegal capture-mode ratio |
| tmr_count | output | 16 | Current count |
| tmr_running | output | 1 | Time base is counting |

## Verification
The free-running path is driven with four ratio/period pairs, from 1:1 at a short period up to 1:16 at a two-cycle period. The irq and sync pulse counts over a fixed window must match closed-form values, and those values differ when the divider is off by one event or the period by one cycle. Trigger-driven runs compare retrigger on against retrigger off, and check one-shot lengths 0 and 1. These show whether a late edge restarts the count and whether the run stops after the right number of periods. The trigger-output and capture-strobe sources are each counted against their own pulse trains. The bench also checks that disabling the module flushes a partial postscale count.

// File: rtl/trig_timer_pkg.sv
// Package: shared widths and the control-word layout of the triggered timer.
// Assumes a single clock domain apart from the trigger input.
package trig_timer_pkg;

    localparam int CNT_W     = 16;
    localparam int RATIO_W   = 4;
    localparam int SHOT_W    = 3;
    localparam int CTRL_W    = 11;
    localparam int CAP_LIMIT = 3;

    // Control word, MSB first: ratio field, then single-bit modes.
    typedef struct packed {
        logic [RATIO_W-1:0] ratio;       // postscale N, interrupt on every N+1
        logic               alt_sync;    // sync output from alternate input
        logic               capture;     // postscaler counts capture strobes
        logic               src_trig;    // postscaler counts accepted triggers
        logic               one_shot;    // limited-length triggered run
        logic               retrig;      // running time base may restart
        logic               trig_en;     // wait for trigger before counting
        logic               on;          // module enable
    } ctrl_t;

endpackage

// File: rtl/tt_trig_sync.sv
// Module: tt_trig_sync
// Brings an asynchronous trigger into the clock domain through STAGES
// flip-flops and emits a one-cycle pulse on each rising edge.
// Assumes the input stays high and low for at least two clocks each.
module tt_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sreg;

    // Shift the raw input through the synchronizer and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sreg <= '0;
        else        sreg <= {sreg[LEN-2:0], din};
    end

    assign rise = sreg[STAGES-1] & ~sreg[STAGES];

    // R7: an edge pulse never lasts two cycles
    a_r7_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tt_time_base.sv
// Module: tt_time_base
// Up-counter from 0 to period with trigger gating, optional retrigger and a
// one-shot run of shot_len+1 periods. It reports period match and
// accepted-trigger pulses. Assumes period is held stable during a run.
module tt_time_base
    import trig_timer_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int SW = SHOT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          on,
    input  logic          trig_en,
    input  logic          retrig,
    input  logic          one_shot,
    input  logic [W-1:0]  period,
    input  logic [SW-1:0] shot_len,
    input  logic          trig_rise,
    output logic [W-1:0]  count,
    output logic          running,
    output logic          pmatch,
    output logic          accept
);

    logic          run_q;
    logic [SW-1:0] shots;

    // Free-running mode counts regardless of the trigger run flag.
    assign running = on & (~trig_en | run_q);
    assign pmatch  = running & (count == period);
    assign accept  = on & trig_en & trig_rise & (~run_q | retrig);

    // Advance the count and manage the run and one-shot period tally.
    always_ff @(posedge clk) begin
        if (!rst_n || !on) begin
            count <= '0;
            run_q <= 1'b0;
            shots <= '0;
        end else if (accept) begin
            count <= '0;
            run_q <= 1'b1;
            shots <= '0;
        end else if (running) begin
            if (pmatch) begin
                count <= '0;
                if (trig_en && one_shot) begin
                    if (shots == shot_len) begin
                        run_q <= 1'b0;
                        shots <= '0;
                    end else begin
                        shots <= shots + SW'(1);
                    end
                end
            end else begin
                count <= count + W'(1);
            end
        end
    end

    // R7: an accepted trigger restarts the count from zero
    a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (running && count == '0));

    // R2: a period match without a trigger wraps to zero
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pmatch && !accept) |=> (count == '0));

    // R8: a trigger without retrigger leaves a running count advancing
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (on && trig_en && run_q && !retrig && trig_rise && count != period)
        |=> (count == $past(count) + W'(1)));

    // R9: the last one-shot period ends the run
    a_r9_shot_end: assert property (@(posedge clk) disable iff (!rst_n)
        (on && trig_en && one_shot && pmatch && !accept && shots == shot_len)
        |=> !running);

endmodule

// File: rtl/tt_postscaler.sv
// Module: tt_postscaler
// Counts events and emits a one-cycle pulse on every (ratio+1)th one. The
// tally clears while disabled and whenever the ratio changes.
// Assumes at most one event per cycle.
module tt_postscaler
    import trig_timer_pkg::*;
#(
    parameter int RW = RATIO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          on,
    input  logic [RW-1:0] ratio,
    input  logic          evt,
    output logic          pulse
);

    logic [RW-1:0] tally;
    logic [RW-1:0] ratio_q;

    // Remember the ratio so that a new setting can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) ratio_q <= '0;
        else        ratio_q <= ratio;
    end

    // Count events and fire once per full group.
    always_ff @(posedge clk) begin
        if (!rst_n || !on || ratio != ratio_q) begin
            tally <= '0;
            pulse <= 1'b0;
        end else if (evt) begin
            if (tally == ratio) begin
                tally <= '0;
                pulse <= 1'b1;
            end else begin
                tally <= tally + RW'(1);
                pulse <= 1'b0;
            end
        end else begin
            pulse <= 1'b0;
        end
    end

    // R3: an interrupt pulse always follows a counted event
    a_r3_irq_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(evt));

    // R11: a disabled module leaves no interrupt behind
    a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> !pulse);

endmodule

// File: rtl/trig_timer.sv
// Module: trig_timer (top)
// Triggered 16-bit timer with a selectable-source interrupt postscaler and
// a sync output. Decodes the control word and wires the parts together.
// Assumes the control word is driven synchronously to clk.
module trig_timer
    import trig_timer_pkg::*;
#(
    parameter int TRIG_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [CNT_W-1:0]  period,
    input  logic [SHOT_W-1:0] shot_len,
    input  logic              trig_in,
    input  logic              cap_strobe,
    input  logic              alt_sync_in,
    output logic              irq,
    output logic              sync_out,
    output logic              cfg_err,
    output logic [CNT_W-1:0]  tmr_count,
    output logic              tmr_running
);

    ctrl_t cw;
    logic  trig_rise;
    logic  pmatch;
    logic  accept;
    logic  ps_evt;

    assign cw = ctrl_t'(ctrl_word);

    tt_trig_sync #(.STAGES(TRIG_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (trig_in),
        .rise  (trig_rise)
    );

    tt_time_base #(.W(CNT_W), .SW(SHOT_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .on        (cw.on),
        .trig_en   (cw.trig_en),
        .retrig    (cw.retrig),
        .one_shot  (cw.one_shot),
        .period    (period),
        .shot_len  (shot_len),
        .trig_rise (trig_rise),
        .count     (tmr_count),
        .running   (tmr_running),
        .pmatch    (pmatch),
        .accept    (accept)
    );

    // Pick the event stream the postscaler divides.
    always_comb begin
        if (cw.capture)       ps_evt = cap_strobe;
        else if (cw.src_trig) ps_evt = accept;
        else                  ps_evt = pmatch;
    end

    tt_postscaler #(.RW(RATIO_W)) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .on    (cw.on),
        .ratio (cw.ratio),
        .evt   (ps_evt),
        .pulse (irq)
    );

    // Select the sync source and flag illegal capture ratios.
    assign sync_out = cw.alt_sync ? alt_sync_in : (pmatch | accept);
    assign cfg_err  = cw.on & cw.capture & (cw.ratio > RATIO_W'(CAP_LIMIT));

    // R10: rollover-driven sync is silent while the module is off
    a_r10_sync_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cw.on && !cw.alt_sync) |-> !sync_out);

endmodule

// File: tb/trig_timer_tb.sv
module trig_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ctrl_word = '0;
    logic [15:0] period = '0;
    logic [2:0]  shot_len = '0;
    logic        trig_in = 1'b0;
    logic        cap_strobe = 1'b0;
    logic        alt_sync_in = 1'b0;
    logic        irq, sync_out, cfg_err, tmr_running;
    logic [15:0] tmr_count;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trig_timer u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .period(period),
        .shot_len(shot_len), .trig_in(trig_in), .cap_strobe(cap_strobe),
        .alt_sync_in(alt_sync_in), .irq(irq), .sync_out(sync_out),
        .cfg_err(cfg_err), .tmr_count(tmr_count), .tmr_running(tmr_running)
    );

    // Control bits: [0] on [1] trig_en [2] retrig [3] one-shot
    // [4] trigger source [5] capture [6] alt sync [10:7] ratio
    function automatic logic [10:0] cw(input int ratio, input logic alt,
        input logic cap, input logic src, input logic os, input logic rt,
        input logic te);
        return {4'(ratio), alt, cap, src, os, rt, te, 1'b1};
    endfunction

    typedef struct packed {
        logic [3:0]  n;
        logic [15:0] p;
        logic [15:0] w;
        logic [15:0] e_irq;
        logic [15:0] e_sync;
    } vec_t;

    // Free-run: irq = W/((N+1)(P+1)), sync = (W+1)/(P+1)
    localparam vec_t VECS [0:3] = '{
        '{4'd0,  16'd4, 16'd50,  16'd10, 16'd10},
        '{4'd2,  16'd3, 16'd60,  16'd5,  16'd15},
        '{4'd15, 16'd1, 16'd100, 16'd3,  16'd50},
        '{4'd1,  16'd2, 16'd30,  16'd5,  16'd10}
    };

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic go_idle();
        ctrl_word = '0;
        trig_in = 1'b0;
        cap_strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_trig();
        trig_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        trig_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n_irq, n_sync, n_run, run_len, dbl;
        int saved;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 sync_out", int'(sync_out), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);
        chk("R1 count", int'(tmr_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 running", int'(tmr_running), 0);

        // R2 R3 R10: table of free-running ratio/period pairs
        for (int v = 0; v < 4; v++) begin
            period = VECS[v].p;
            ctrl_word = cw(int'(VECS[v].n), 0, 0, 0, 0, 0, 0);
            n_irq = 0; n_sync = 0; dbl = 0; run_len = 0;
            for (int i = 0; i < int'(VECS[v].w); i++) begin
                @(negedge clk);
                if (irq) begin n_irq++; run_len++; end else run_len = 0;
                if (run_len > 1) dbl++;
                if (sync_out) n_sync++;
            end
            chk("R3 irq count", n_irq, int'(VECS[v].e_irq));
            chk("R2 R10 sync rollover count", n_sync, int'(VECS[v].e_sync));
            chk("R3 irq single cycle", dbl, 0);
            go_idle();
        end

        // R2: count value walk
        period = 16'd6;
        ctrl_word = cw(0, 0, 0, 0, 0, 0, 0);
        repeat (9) @(negedge clk);
        chk("R2 count after 9 clocks", int'(tmr_count), 2);
        go_idle();

        // R7: idle until trigger, then runs
        period = 16'd4;
        ctrl_word = cw(0, 0, 0, 0, 0, 0, 1);
        n_sync = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (sync_out) n_sync++;
        end
        chk("R7 idle running", int'(tmr_running), 0);
        chk("R7 idle count", int'(tmr_count), 0);
        chk("R7 idle sync", n_sync, 0);
        pulse_trig();
        chk("R7 running after trigger", int'(tmr_running), 1);
        go_idle();

        // R8: retrigger disabled keeps counting
        period = 16'd100;
        ctrl_word = cw(0, 0, 0, 0, 0, 0, 1);
        pulse_trig();
        repeat (20) @(negedge clk);
        pulse_trig();
        repeat (6) @(negedge clk);
        chk("R8 no restart", int'(tmr_count > 16'd20), 1);
        go_idle();

        // R8: retrigger enabled restarts
        ctrl_word = cw(0, 0, 0, 0, 0, 1, 1);
        pulse_trig();
        repeat (20) @(negedge clk);
        saved = int'(tmr_count);
        pulse_trig();
        repeat (6) @(negedge clk);
        chk("R8 restart", int'(tmr_count < 16'd15 && saved > 20), 1);
        go_idle();

        // R9: one-shot lengths 1 and 0 with period 3
        period = 16'd3;
        for (int k = 0; k < 2; k++) begin
            shot_len = 3'(1 - k);
            ctrl_word = cw(0, 0, 0, 0, 1, 0, 1);
            trig_in = 1'b1;
            n_run = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (i == 2) trig_in = 1'b0;
                if (tmr_running) n_run++;
            end
            chk("R9 one-shot cycles", n_run, (2 - k) * 4);
            chk("R9 idle count after shot", int'(tmr_count), 0);
            go_idle();
        end

        // R4: postscaler counts accepted triggers
        period = 16'd200;
        ctrl_word = cw(1, 0, 0, 1, 0, 1, 1);
        n_irq = 0; n_sync = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (irq) n_irq++;
            if (sync_out) n_sync++;
            trig_in = (i % 10 < 3 && i < 40);
        end
        chk("R4 trigger-source irqs", n_irq, 2);
        chk("R10 sync on accepted triggers", n_sync, 4);
        go_idle();

        // R5 R6: capture strobes
        period = 16'd1000;
        ctrl_word = cw(2, 0, 1, 0, 0, 0, 0);
        n_irq = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq) n_irq++;
            cap_strobe = (i % 4 == 1 && i < 36);
        end
        chk("R5 capture irqs", n_irq, 3);
        chk("R6 legal ratio no error", int'(cfg_err), 0);
        ctrl_word = cw(5, 0, 1, 0, 0, 0, 0);
        @(negedge clk);
        chk("R6 ratio 5 in capture", int'(cfg_err), 1);
        ctrl_word = cw(5, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R6 ratio 5 outside capture", int'(cfg_err), 0);
        go_idle();

        // R10: alternate sync source
        ctrl_word = cw(0, 1, 0, 0, 0, 0, 0);
        alt_sync_in = 1'b1;
        @(negedge clk);
        chk("R10 alt high", int'(sync_out), 1);
        alt_sync_in = 1'b0;
        @(negedge clk);
        chk("R10 alt low", int'(sync_out), 0);
        go_idle();

        // R11: disabling clears a partial postscale tally
        period = 16'd4;
        ctrl_word = cw(1, 0, 0, 0, 0, 0, 0);
        repeat (7) @(negedge clk);
        ctrl_word = '0;
        repeat (2) @(negedge clk);
        ctrl_word = cw(1, 0, 0, 0, 0, 0, 0);
        n_irq = 0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (irq) n_irq++;
        end
        chk("R11 tally cleared by disable", n_irq, 0);
        go_idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule